// File: doc/BRIEF.md
# Four-Channel Doorbell Messaging Unit

This block connects two processor sides through four one-way message channels. The sending side (side B) posts a 32-bit word by writing one of four transmit addresses. That write loads the word into the matching receive register on the receiving side (side A). The same write sets a per-channel full flag. Each posted write therefore acts as one doorbell event: a message-signalled interrupt whose payload is the written word. By convention the payload for channel n is the value n.

Side A sees the full flags in a status register and sets per-channel interrupt enables in a control register by read-modify-write. A single registered interrupt line is high while any enabled channel is full. Side A acknowledges a channel by reading its receive register, which clears the flag.

A build-time parameter selects one of two bit layouts for the flags and enables. In the legacy layout, channel n uses bit 27-n. In the packed layout, channel n uses bit n.

Top module: `mu_doorbell`

## Requirements
- R1: A side-B write (`b_wr_en`=1) to offset 0x00+4*n, for n in 0..3, loads `b_wdata` into receive register n and sets full flag n at that same clock edge.
- R2: A further side-B write to channel n while its flag is set replaces the stored word, and the flag stays set.
- R3: A side-A read (`a_rd_en`=1) of offset 0x10+4*n returns receive register n on `a_rdata` one cycle later and clears full flag n at that edge.
- R4: When a side-B write and a side-A read hit channel n in the same cycle, the read returns the old word, the new word is stored, and the flag stays set.
- R5: Reading the status register at offset 0x20 returns the full flags at bit 27-n for channel n when LAYOUT=0, and at bit n when LAYOUT=1. All other bits read zero.
- R6: A side-A write (`a_wr_en`=1) to the control register at offset 0x24 sets enable n from the same bit position that R5 uses. Reading 0x24 returns the enables at those positions, and all other bits read zero.
- R7: `irq_o` is registered. It goes high one cycle after any channel is both full and enabled, and goes low one cycle after no channel is.
- R8: A full channel whose enable is clear does not raise `irq_o`, but its flag is still visible in the status register.
- R9: After reset, all flags, enables and receive registers are zero, and `irq_o` is low.
- R10: Side-A reads of any other offset, including offsets that are not word aligned, return zero. Side-A writes to any offset other than 0x24 have no effect. Side-B writes to any offset other than the four transmit addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Active-low asynchronous reset |
| b_wr_en | input | 1 | Side-B write strobe |
| b_addr | input | AW (8) | Side-B byte offset |
| b_wdata | input | DW (32) | Side-B write data |
| a_wr_en | input | 1 | Side-A write strobe |
| a_rd_en | input | 1 | Side-A read strobe |
| a_addr | input | AW (8) | Side-A byte offset |
| a_wdata | input | DW (32) | Side-A write data |
| a_rdata | output | DW (32) | Side-A read data, valid the cycle after the read strobe |
| irq_o | output | 1 | Registered interrupt to side A |

## Verification
A stuck or wrongly cleared full flag shows in the status word on the next side-A read. It also shows on `irq_o` one cycle after the flag changes, which the bench samples at that exact cycle. A flag or enable placed at the wrong lane shows as a wrong bit in the status or control readback. Both layouts are built side by side and driven with the same stimulus, so a layout swap shows up in the first status read. A wrong collision priority shows in the two receive reads that follow the colliding cycle: the old word must come first, then the new word.

// File: rtl/mu_db_pkg.sv
package mu_db_pkg;
   localparam int unsigned MU_CHANS     = 4;
   localparam int unsigned MU_STRIDE    = 4;
   localparam int unsigned LAYOUT_LEGACY = 0;
   localparam int unsigned LAYOUT_PACKED = 1;
   localparam int unsigned LEGACY_TOP   = 27;
endpackage

// File: rtl/mu_db_chan.sv
module mu_db_chan #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          ack_i,
   input  logic [DW-1:0] data_i,
   output logic [DW-1:0] data_o,
   output logic          full_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_o <= '0;
         full_o <= 1'b0;
      end else begin
         if (load_i) data_o <= data_i;
         if (load_i)      full_o <= 1'b1;
         else if (ack_i)  full_o <= 1'b0;
      end
   end

   AST_LOAD_SETS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (full_o && data_o == $past(data_i))); // R1
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && !load_i) |=> !full_o); // R3
   AST_COLLIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && load_i) |=> full_o); // R4
   AST_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !load_i |=> $stable(data_o)); // R2
endmodule

// File: rtl/mu_db_lane_map.sv
module mu_db_lane_map #(
   parameter int unsigned LAYOUT = 0,
   parameter int unsigned NCH    = 4,
   parameter int unsigned DW     = 32
) (
   input  logic [NCH-1:0] flag_i,
   input  logic [NCH-1:0] en_i,
   input  logic [DW-1:0]  wr_word_i,
   output logic [DW-1:0]  flag_word_o,
   output logic [DW-1:0]  en_word_o,
   output logic [NCH-1:0] en_wr_o
);
   import mu_db_pkg::*;

   generate
      if (LAYOUT == LAYOUT_LEGACY) begin : g_legacy
         if (DW <= LEGACY_TOP) begin : g_bad_dw
            $error("legacy layout needs DW above 27");
         end
         for (genvar n = 0; n < NCH; n++) begin : g_lane
            localparam int unsigned POS = LEGACY_TOP - n;
            assign flag_word_o[POS] = flag_i[n];
            assign en_word_o[POS]   = en_i[n];
            assign en_wr_o[n]       = wr_word_i[POS];
         end
         for (genvar b = 0; b < DW; b++) begin : g_zero
            if (b > LEGACY_TOP || b < LEGACY_TOP - NCH + 1) begin : g_z
               assign flag_word_o[b] = 1'b0;
               assign en_word_o[b]   = 1'b0;
            end
         end
      end else if (LAYOUT == LAYOUT_PACKED) begin : g_packed
         if (DW < NCH) begin : g_bad_dw
            $error("packed layout needs DW of at least NCH");
         end
         for (genvar n = 0; n < NCH; n++) begin : g_lane
            assign flag_word_o[n] = flag_i[n];
            assign en_word_o[n]   = en_i[n];
            assign en_wr_o[n]     = wr_word_i[n];
         end
         for (genvar b = NCH; b < DW; b++) begin : g_zero
            assign flag_word_o[b] = 1'b0;
            assign en_word_o[b]   = 1'b0;
         end
      end else begin : g_bad_layout
         $error("LAYOUT must be 0 or 1");
      end
   endgenerate

   logic unused_word;
   assign unused_word = ^wr_word_i;
endmodule

// File: rtl/mu_doorbell.sv
module mu_doorbell #(
   parameter int unsigned LAYOUT  = 0,
   parameter int unsigned NCH     = 4,
   parameter int unsigned DW      = 32,
   parameter int unsigned AW      = 8,
   parameter int unsigned TX_BASE = 'h00,
   parameter int unsigned RX_BASE = 'h10,
   parameter int unsigned SR_OFF  = 'h20,
   parameter int unsigned CR_OFF  = 'h24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          b_wr_en,
   input  logic [AW-1:0] b_addr,
   input  logic [DW-1:0] b_wdata,
   input  logic          a_wr_en,
   input  logic          a_rd_en,
   input  logic [AW-1:0] a_addr,
   input  logic [DW-1:0] a_wdata,
   output logic [DW-1:0] a_rdata,
   output logic          irq_o
);
   import mu_db_pkg::*;

   localparam int unsigned TX_END = TX_BASE + MU_STRIDE * NCH;
   localparam int unsigned RX_END = RX_BASE + MU_STRIDE * NCH;

   generate
      if (NCH != MU_CHANS) begin : g_bad_nch
         $error("channel count is fixed at four");
      end
      if (CR_OFF >= (1 << AW) || TX_END > (1 << AW) || RX_END > (1 << AW)) begin : g_bad_aw
         $error("address map does not fit in AW bits");
      end
      if (RX_BASE < TX_END && TX_BASE < RX_END) begin : g_bad_map
         $error("transmit and receive windows overlap");
      end
   endgenerate

   logic [NCH-1:0] load_v, ack_v, full_v;
   logic [DW-1:0]  data_v [NCH];
   logic [NCH-1:0] en_q, en_wr;
   logic [DW-1:0]  flag_word, en_word;
   logic [DW-1:0]  rd_mux;
   logic           rd_hit;

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      localparam logic [AW-1:0] TX_ADDR = AW'(TX_BASE + MU_STRIDE * n);
      localparam logic [AW-1:0] RX_ADDR = AW'(RX_BASE + MU_STRIDE * n);
      assign load_v[n] = b_wr_en && (b_addr == TX_ADDR);
      assign ack_v[n]  = a_rd_en && (a_addr == RX_ADDR);

      mu_db_chan #(.DW(DW)) chan_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .load_i (load_v[n]),
         .ack_i  (ack_v[n]),
         .data_i (b_wdata),
         .data_o (data_v[n]),
         .full_o (full_v[n])
      );
   end

   mu_db_lane_map #(.LAYOUT(LAYOUT), .NCH(NCH), .DW(DW)) map_i (
      .flag_i      (full_v),
      .en_i        (en_q),
      .wr_word_i   (a_wdata),
      .flag_word_o (flag_word),
      .en_word_o   (en_word),
      .en_wr_o     (en_wr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 en_q <= '0;
      else if (a_wr_en && a_addr == AW'(CR_OFF))  en_q <= en_wr;
   end

   always_comb begin
      rd_mux = '0;
      rd_hit = 1'b0;
      for (int n = 0; n < NCH; n++) begin
         if (a_addr == AW'(RX_BASE + MU_STRIDE * n)) begin
            rd_mux = data_v[n];
            rd_hit = 1'b1;
         end
      end
      if (a_addr == AW'(SR_OFF)) begin
         rd_mux = flag_word;
         rd_hit = 1'b1;
      end
      if (a_addr == AW'(CR_OFF)) begin
         rd_mux = en_word;
         rd_hit = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         a_rdata <= '0;
         irq_o   <= 1'b0;
      end else begin
         if (a_rd_en) a_rdata <= rd_mux;
         irq_o <= |(full_v & en_q);
      end
   end

   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (en_q == '0) |=> !irq_o); // R8
   AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      ((full_v & en_q) != '0) |=> irq_o); // R7
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (a_rd_en && !rd_hit) |=> (a_rdata == '0)); // R10
   AST_SR_ONEHOT_WR: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(load_v)); // R1
endmodule

// File: tb/mu_doorbell_tb_top.sv
`timescale 1ns/1ps
module mu_doorbell_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        b_wr_en = 1'b0, a_wr_en = 1'b0, a_rd_en = 1'b0;
   logic [7:0]  b_addr = '0, a_addr = '0;
   logic [31:0] b_wdata = '0, a_wdata = '0;
   logic [31:0] rdata_l, rdata_p;
   logic        irq_l, irq_p;
   int          total = 0;
   int          bad = 0;

   always #2.5 clk = ~clk;

   mu_doorbell #(.LAYOUT(0)) dut_i (
      .clk(clk), .rst_n(rst_n), .b_wr_en(b_wr_en), .b_addr(b_addr), .b_wdata(b_wdata),
      .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(rdata_l), .irq_o(irq_l));

   mu_doorbell #(.LAYOUT(1)) dut_p_i (
      .clk(clk), .rst_n(rst_n), .b_wr_en(b_wr_en), .b_addr(b_addr), .b_wdata(b_wdata),
      .a_wr_en(a_wr_en), .a_rd_en(a_rd_en), .a_addr(a_addr), .a_wdata(a_wdata),
      .a_rdata(rdata_p), .irq_o(irq_p));

   // expected word for a 4-bit channel mask, from R5: legacy bit 27-n, packed bit n
   function automatic logic [31:0] lanes(input int lay, input logic [3:0] m);
      logic [31:0] w = '0;
      for (int n = 0; n < 4; n++) if (m[n]) w[lay == 0 ? 27 - n : n] = 1'b1;
      return w;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
      end
   endtask

   task automatic b_write(input logic [7:0] addr, input logic [31:0] d);
      @(negedge clk); b_wr_en = 1'b1; b_addr = addr; b_wdata = d;
      @(posedge clk);
      @(negedge clk); b_wr_en = 1'b0;
   endtask

   task automatic a_write(input logic [7:0] addr, input logic [31:0] d);
      @(negedge clk); a_wr_en = 1'b1; a_addr = addr; a_wdata = d;
      @(posedge clk);
      @(negedge clk); a_wr_en = 1'b0;
   endtask

   task automatic a_read(input logic [7:0] addr, output logic [31:0] rl, output logic [31:0] rp);
      @(negedge clk); a_rd_en = 1'b1; a_addr = addr;
      @(posedge clk); #1; rl = rdata_l; rp = rdata_p;
      @(negedge clk); a_rd_en = 1'b0;
   endtask

   task automatic read_both(input string tag, input logic [7:0] addr,
                            input logic [31:0] el, input logic [31:0] ep);
      logic [31:0] rl, rp;
      a_read(addr, rl, rp);
      check({tag, " legacy"}, rl, el);
      check({tag, " packed"}, rp, ep);
   endtask

   task automatic check_irq(input string tag, input logic el, input logic ep);
      check({tag, " irq legacy"}, {31'b0, irq_l}, {31'b0, el});
      check({tag, " irq packed"}, {31'b0, irq_p}, {31'b0, ep});
   endtask

   task automatic t_reset;
      check_irq("R9 reset", 1'b0, 1'b0);
      read_both("R9 reset status", 8'h20, 32'h0, 32'h0);
      read_both("R9 reset control", 8'h24, 32'h0, 32'h0);
      for (int n = 0; n < 4; n++)
         read_both("R9 reset rx", 8'(8'h10 + 4 * n), 32'h0, 32'h0);
   endtask

   task automatic t_channels;
      a_write(8'h24, 32'h0F00000F);
      read_both("R6 control readback", 8'h24, lanes(0, 4'hF), lanes(1, 4'hF));
      for (int n = 0; n < 4; n++) begin
         b_write(8'(4 * n), 32'(n));
         // flag set at write edge; irq follows one edge later
         check_irq("R7 before rise", 1'b0, 1'b0);
         read_both("R1 R5 status", 8'h20, lanes(0, 4'(1 << n)), lanes(1, 4'(1 << n)));
         check_irq("R7 rise", 1'b1, 1'b1);
         read_both("R1 R3 rx data", 8'(8'h10 + 4 * n), 32'(n), 32'(n));
         check_irq("R7 hold one cycle", 1'b1, 1'b1);
         @(posedge clk); #1;
         check_irq("R7 fall", 1'b0, 1'b0);
         read_both("R3 flag cleared", 8'h20, 32'h0, 32'h0);
      end
   endtask

   task automatic t_overwrite;
      b_write(8'h08, 32'h1111_2222);
      b_write(8'h08, 32'hCAFE_0002);
      read_both("R2 flag kept", 8'h20, lanes(0, 4'b0100), lanes(1, 4'b0100));
      read_both("R2 new data", 8'h18, 32'hCAFE_0002, 32'hCAFE_0002);
      read_both("R2 cleared", 8'h20, 32'h0, 32'h0);
   endtask

   task automatic t_collide;
      logic [31:0] rl, rp;
      b_write(8'h0C, 32'hAAAA_0003);
      @(negedge clk);
      b_wr_en = 1'b1; b_addr = 8'h0C; b_wdata = 32'hBBBB_0003;
      a_rd_en = 1'b1; a_addr = 8'h1C;
      @(posedge clk); #1; rl = rdata_l; rp = rdata_p;
      @(negedge clk); b_wr_en = 1'b0; a_rd_en = 1'b0;
      check("R4 old word legacy", rl, 32'hAAAA_0003);
      check("R4 old word packed", rp, 32'hAAAA_0003);
      read_both("R4 flag stays", 8'h20, lanes(0, 4'b1000), lanes(1, 4'b1000));
      read_both("R4 new word", 8'h1C, 32'hBBBB_0003, 32'hBBBB_0003);
   endtask

   task automatic t_mask;
      a_write(8'h24, lanes(0, 4'b0001) | lanes(1, 4'b0001));
      b_write(8'h08, 32'h2);
      @(posedge clk); #1;
      check_irq("R8 masked", 1'b0, 1'b0);
      read_both("R8 flag visible", 8'h20, lanes(0, 4'b0100), lanes(1, 4'b0100));
      check_irq("R8 still masked", 1'b0, 1'b0);
      a_write(8'h24, lanes(0, 4'b0101) | lanes(1, 4'b0101));
      // enable set at write edge; irq follows at next edge
      @(posedge clk); #1;
      check_irq("R7 R6 unmask", 1'b1, 1'b1);
      a_write(8'h24, 32'h0);
      @(posedge clk); #1;
      check_irq("R6 remask", 1'b0, 1'b0);
      read_both("R3 ack masked", 8'h18, 32'h2, 32'h2);
   endtask

   task automatic t_unmapped;
      read_both("R10 hole", 8'h30, 32'h0, 32'h0);
      read_both("R10 unaligned", 8'h12, 32'h0, 32'h0);
      b_write(8'h10, 32'hDEAD_BEEF);
      b_write(8'h02, 32'hDEAD_BEEF);
      read_both("R10 side-B stray", 8'h20, 32'h0, 32'h0);
      a_write(8'h04, 32'hFFFF_FFFF);
      a_write(8'h20, 32'hFFFF_FFFF);
      read_both("R10 side-A stray ctl", 8'h24, 32'h0, 32'h0);
      read_both("R10 side-A stray sr", 8'h20, 32'h0, 32'h0);
      read_both("R10 rx untouched", 8'h14, 32'h1, 32'h1);
   endtask

   initial begin
      #(200000 * 5);
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      t_reset();
      t_channels();
      t_overwrite();
      t_collide();
      t_mask();
      t_unmapped();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule